// File: doc/BRIEF.md
# Cross-Bus Signal Interrupt Register

This block is a small status register that lets masters on a remote system bus raise interrupts on the local processor. It holds two signal flags. The low flag requests interrupt level 1 and the high flag requests interrupt level 5. It also holds a board-fail status flag.

A remote write can only set a signal flag. A local write can only clear one. A flag that is set keeps its request pending until local software clears it. Each flag has its own enable input, which gates its request. A single encoded level output shows the highest pending request.

The board-fail flag follows the state of a shared active-low, open-drain fail line. The block pulls that line low while the local fail request is asserted or the watchdog timeout input is active. The flag then reports the sensed line, whichever agent pulled it low.

Top module: `sigint_reg`

## Requirements
- R1: A synchronous active-high `rst` clears both signal flags and the fail status flag. Immediately after reset, `rd_data` is 0, `irq_lo` and `irq_hi` are 0, and `irq_level` is 0.
- R2: A remote write (`rmt_wr`=1) sets the low flag when `rmt_wdata` bit 0 is 1, and sets the high flag when bit 1 is 1. The new value shows from the next clock edge. A local write can never set a flag.
- R3: A local write (`loc_wr`=1) clears the low flag when `loc_wdata` bit 0 is 1, and clears the high flag when bit 1 is 1. A 0 in either bit of a local or remote write leaves that flag unchanged.
- R4: If a remote set and a local clear target the same flag in the same clock, the flag ends up set.
- R5: `irq_lo` is 1 exactly while the low flag is set and `irq_en` bit 0 is 1. It stays asserted until the flag is cleared.
- R6: `irq_hi` is 1 exactly while the high flag is set and `irq_en` bit 1 is 1. When it is active, `irq_level` is 5.
- R7: `irq_level` is 5 when `irq_hi` is 1. Otherwise it is 1 when `irq_lo` is 1. Otherwise it is 0.
- R8: `bfail_pull` is 1 (the block pulls the fail line low) in the same cycle that `fail_req` or `wdog_to` is 1, and 0 otherwise.
- R9: Read bit 2 is the fail status. It reads 1 from the clock edge after `bfail_line_n` is sampled low, whatever agent drove the line. Read bit 0 is the low flag, read bit 1 is the high flag, and all other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rmt_wr | input | 1 | Remote bus write strobe |
| rmt_wdata | input | 2 | Remote set mask (bit 0 low flag, bit 1 high flag) |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 2 | Local clear mask (bit 0 low flag, bit 1 high flag) |
| irq_en | input | 2 | Interrupt enables (bit 0 low, bit 1 high) |
| fail_req | input | 1 | Local request to assert board fail |
| wdog_to | input | 1 | Watchdog timeout, asserts board fail |
| bfail_line_n | input | 1 | Sensed state of the active-low fail line |
| bfail_pull | output | 1 | 1 pulls the open-drain fail line low |
| irq_lo | output | 1 | Level 1 request |
| irq_hi | output | 1 | Level 5 request |
| irq_level | output | 3 | Encoded highest pending level (0, 1 or 5) |
| rd_data | output | 8 | Register read value |

## Verification
A wrong flag state shows at the ports one edge after the write that caused it. It appears both in `rd_data` and in the request outputs and level.

The bench therefore compares the whole output set every cycle, so a lost set or a premature clear is caught in the very next sample. The set-versus-clear race and a write with zero data are placed right after states where a flag would visibly flip. The priority encoder is exercised with both requests active and then with the high request masked off. A stale or missing fail status shows one cycle after the line changes, and each of the three line drivers is exercised on its own.

// File: rtl/sigint_pkg.sv
package sigint_pkg;
    localparam int NUM_SIG = 2;
    localparam int REG_W   = 8;
    localparam int LVL_W   = 3;

    // Read-word bit positions
    localparam int LO_IDX   = 0;
    localparam int HI_IDX   = 1;
    localparam int FAIL_IDX = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE = 3'd0,
        LVL_LOW  = 3'd1,
        LVL_HIGH = 3'd5
    } irq_lvl_e;

    typedef struct packed {
        logic fail;
        logic hi;
        logic lo;
    } sig_state_t;

    // Fixed interrupt level of each signal flag
    function automatic irq_lvl_e sig_level(input int idx);
        return (idx == HI_IDX) ? LVL_HIGH : LVL_LOW;
    endfunction

    // Highest-priority level among active requests
    function automatic irq_lvl_e pick_level(input logic [NUM_SIG-1:0] req);
        irq_lvl_e lvl;
        lvl = LVL_NONE;
        for (int i = 0; i < NUM_SIG; i++) begin
            if (req[i] && (sig_level(i) > lvl)) lvl = sig_level(i);
        end
        return lvl;
    endfunction
endpackage

// File: rtl/sigint_cell.sv
module sigint_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic req_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;   // set beats a concurrent clear
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign req_o  = flag_q & en_i;
endmodule

// File: rtl/sigint_fail_mon.sv
module sigint_fail_mon (
    input  logic clk,
    input  logic rst,
    input  logic fail_req,
    input  logic wdog_to,
    input  logic line_n,
    output logic pull_o,
    output logic status_o
);
    logic status_q;

    assign pull_o = fail_req | wdog_to;

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= ~line_n;
    end

    assign status_o = status_q;
endmodule

// File: rtl/sigint_lvl_enc.sv
module sigint_lvl_enc
    import sigint_pkg::*;
(
    input  logic [NUM_SIG-1:0] req_i,
    output logic [LVL_W-1:0]   level_o
);
    irq_lvl_e lvl;

    always_comb lvl = pick_level(req_i);

    assign level_o = lvl;
endmodule

// File: rtl/sigint_reg.sv
module sigint_reg
    import sigint_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rmt_wr,
    input  logic [NUM_SIG-1:0] rmt_wdata,
    input  logic               loc_wr,
    input  logic [NUM_SIG-1:0] loc_wdata,
    input  logic [NUM_SIG-1:0] irq_en,
    input  logic               fail_req,
    input  logic               wdog_to,
    input  logic               bfail_line_n,
    output logic               bfail_pull,
    output logic               irq_lo,
    output logic               irq_hi,
    output logic [LVL_W-1:0]   irq_level,
    output logic [REG_W-1:0]   rd_data
);
    logic [NUM_SIG-1:0] flags;
    logic [NUM_SIG-1:0] reqs;
    logic               fail_stat;
    sig_state_t         st;

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
        sigint_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (rmt_wr & rmt_wdata[g]),
            .clr_i  (loc_wr & loc_wdata[g]),
            .en_i   (irq_en[g]),
            .flag_o (flags[g]),
            .req_o  (reqs[g])
        );
    end

    sigint_fail_mon u_fail (
        .clk      (clk),
        .rst      (rst),
        .fail_req (fail_req),
        .wdog_to  (wdog_to),
        .line_n   (bfail_line_n),
        .pull_o   (bfail_pull),
        .status_o (fail_stat)
    );

    sigint_lvl_enc u_enc (
        .req_i   (reqs),
        .level_o (irq_level)
    );

    always_comb begin
        st.lo   = flags[LO_IDX];
        st.hi   = flags[HI_IDX];
        st.fail = fail_stat;
        rd_data = '0;
        rd_data[LO_IDX]   = st.lo;
        rd_data[HI_IDX]   = st.hi;
        rd_data[FAIL_IDX] = st.fail;
    end

    assign irq_lo = reqs[LO_IDX];
    assign irq_hi = reqs[HI_IDX];
endmodule

// File: rtl/sigint_reg_chk.sv
module sigint_reg_chk
    import sigint_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rmt_wr,
    input logic [NUM_SIG-1:0] rmt_wdata,
    input logic               loc_wr,
    input logic [NUM_SIG-1:0] loc_wdata,
    input logic [NUM_SIG-1:0] irq_en,
    input logic               fail_req,
    input logic               wdog_to,
    input logic               bfail_line_n,
    input logic               bfail_pull,
    input logic               irq_lo,
    input logic               irq_hi,
    input logic [LVL_W-1:0]   irq_level,
    input logic [REG_W-1:0]   rd_data
);
    // R2
    remote_set_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (rmt_wr && rmt_wdata[LO_IDX]) |=> rd_data[LO_IDX]);

    // R3
    local_clr_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_wr && loc_wdata[LO_IDX] && !(rmt_wr && rmt_wdata[LO_IDX])) |=> !rd_data[LO_IDX]);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rmt_wr && !loc_wr) |=> $stable(rd_data[HI_IDX:LO_IDX]));

    // R4
    race_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (rmt_wr && rmt_wdata[HI_IDX] && loc_wr && loc_wdata[HI_IDX]) |=> rd_data[HI_IDX]);

    // R5
    irq_lo_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (rd_data[LO_IDX] && irq_en[LO_IDX]));

    // R6
    lvl_high_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> (irq_level == 3'd5));

    // R7
    lvl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && !irq_hi) |-> (irq_level == 3'd1));

    // R7
    lvl_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_lo && !irq_hi) |-> (irq_level == 3'd0));

    // R8
    pull_on_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_req || wdog_to) |-> bfail_pull);

    // R8
    pull_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!fail_req && !wdog_to) |-> !bfail_pull);

    // R9
    fail_status_chk: assert property (@(posedge clk) disable iff (rst)
        !bfail_line_n |=> rd_data[FAIL_IDX]);
endmodule

bind sigint_reg sigint_reg_chk chk_i (.*);

// File: tb/sigint_reg_test.sv
module sigint_reg_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       rmt_wr, loc_wr;
    logic [1:0] rmt_wdata, loc_wdata, irq_en;
    logic       fail_req, wdog_to, ext_pull;
    logic       bfail_line_n, bfail_pull;
    logic       irq_lo, irq_hi;
    logic [2:0] irq_level;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // 125 MHz
    always #4 clk = ~clk;

    // wired-AND open-drain line
    assign bfail_line_n = ~(bfail_pull | ext_pull);

    sigint_reg uut (
        .clk(clk), .rst(rst),
        .rmt_wr(rmt_wr), .rmt_wdata(rmt_wdata),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .irq_en(irq_en), .fail_req(fail_req), .wdog_to(wdog_to),
        .bfail_line_n(bfail_line_n), .bfail_pull(bfail_pull),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_level(irq_level),
        .rd_data(rd_data)
    );

    typedef struct {
        string      tag;
        logic [14:0] v;   // {rd_data, irq_lo, irq_hi, irq_level, pull}
    } exp_t;

    exp_t sb[$];
    logic m_lo = 0, m_hi = 0;

    task automatic step(input string tag, input logic r,
                        input logic rw, input logic [1:0] rd,
                        input logic lw, input logic [1:0] ld,
                        input logic [1:0] en, input logic fr,
                        input logic wd, input logic ex);
        exp_t e;
        logic nlo, nhi, nfs, elo, ehi;
        logic [2:0] elvl;
        @(negedge clk);
        rst = r; rmt_wr = rw; rmt_wdata = rd; loc_wr = lw; loc_wdata = ld;
        irq_en = en; fail_req = fr; wdog_to = wd; ext_pull = ex;
        if (r) begin
            nlo = 0; nhi = 0; nfs = 0;
        end else begin
            nlo = (rw & rd[0]) | (m_lo & ~(lw & ld[0]));
            nhi = (rw & rd[1]) | (m_hi & ~(lw & ld[1]));
            nfs = fr | wd | ex;
        end
        m_lo = nlo; m_hi = nhi;
        elo = nlo & en[0];
        ehi = nhi & en[1];
        elvl = ehi ? 3'd5 : (elo ? 3'd1 : 3'd0);
        e.tag = tag;
        e.v = {5'b0, nfs, nhi, nlo, elo, ehi, elvl, fr | wd};
        sb.push_back(e);
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [14:0] act;
                e = sb.pop_front();
                act = {rd_data, irq_lo, irq_hi, irq_level, bfail_pull};
                n_checks++;
                if (act !== e.v) begin
                    n_errors++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; rmt_wr = 0; rmt_wdata = 0; loc_wr = 0; loc_wdata = 0;
        irq_en = 0; fail_req = 0; wdog_to = 0; ext_pull = 0;
        step("R1 reset",               1, 0,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R1 after reset",         0, 0,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R2 local cannot set",    0, 0,2'b00, 1,2'b11, 2'b11, 0,0,0);
        step("R3 remote zero write",   0, 1,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R2 R5 set low",          0, 1,2'b01, 0,2'b00, 2'b01, 0,0,0);
        step("R5 request persists",    0, 0,2'b00, 0,2'b00, 2'b01, 0,0,0);
        step("R5 masked low",          0, 0,2'b00, 0,2'b00, 2'b00, 0,0,0);
        step("R3 local zero write",    0, 0,2'b00, 1,2'b00, 2'b01, 0,0,0);
        step("R6 R7 set high",         0, 1,2'b10, 0,2'b00, 2'b11, 0,0,0);
        step("R3 remote zero keeps",   0, 1,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R7 high masked",         0, 0,2'b00, 0,2'b00, 2'b01, 0,0,0);
        step("R3 clear low",           0, 0,2'b00, 1,2'b01, 2'b11, 0,0,0);
        step("R4 race high",           0, 1,2'b10, 1,2'b10, 2'b11, 0,0,0);
        step("R4 race low",            0, 1,2'b01, 1,2'b01, 2'b11, 0,0,0);
        step("R3 clear both",          0, 0,2'b00, 1,2'b11, 2'b11, 0,0,0);
        step("R8 R9 local fail",       0, 0,2'b00, 0,2'b00, 2'b11, 1,0,0);
        step("R9 fail released",       0, 0,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R8 R9 watchdog",         0, 0,2'b00, 0,2'b00, 2'b11, 0,1,0);
        step("R9 external pull",       0, 0,2'b00, 0,2'b00, 2'b11, 0,0,1);
        step("R2 set both",            0, 1,2'b11, 0,2'b00, 2'b11, 0,0,0);
        step("R1 reset clears",        1, 0,2'b00, 0,2'b00, 2'b11, 0,0,0);
        step("R1 idle after reset",    0, 0,2'b00, 0,2'b00, 2'b11, 0,0,0);
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule